// File: doc/BRIEF.md
# Regulator Operating Mode Selector

This block decides, for one switching regulator channel, which drive mode and which voltage code the converter gets, and whether the channel runs at all. It holds the channel's programmed settings and combines them with the system power state and two standby pins. The standby condition counts only when both pins are high. In normal run the channel follows its mode field and its normal set point. When standby is qualified, it moves to the standby behaviour of that mode and to the standby set point.

Two low-power-off states, memory hold and user off, each have their own keep-alive bit. A channel kept alive runs in PFM on its standby set point. It freezes those settings until the startup sequencer strobes the channel's own time slot. A channel kept alive is never switched off while the sequence runs. At its slot it picks up the normal settings. Register reads always return what software wrote, not what is in effect.

Top module: `regmode_sel`

## Requirements
- R1: The standby condition is the AND of `stby_pin_a` and `stby_pin_b`, each passed through a two-stage synchronizer. A pin change sampled at clock edge k shows on the drive outputs after edge k+2.
- R2: In run state (`pwr_state` = 1), mode field 4'b1110 gives drive mode 2 (pulse-skipping PWM) without standby and drive mode 3 (PFM) with standby. Drive mode codes are 0 off, 1 PWM, 2 pulse-skipping PWM, 3 PFM.
- R3: In run state, mode field 4'b1111 gives drive mode 3 with or without standby.
- R4: In run state, every other mode field value gives drive mode 1 with or without standby.
- R5: In run state, `drv_volt` is the standby set point while standby is qualified, and the normal set point otherwise.
- R6: Reset loads the mode field with MODE_RST and the normal set point with VSET_RST. Until software writes the standby set point (address 2), it equals the normal set point, and it follows later writes to the normal one. Register addresses are 0 mode, 1 normal set point, 2 standby set point, 3 keep-alive bits (bit 0 memory hold, bit 1 user off).
- R7: `rd_data` returns the programmed register contents, zero-extended, independent of the mode in effect.
- R8: In memory-hold state (`pwr_state` = 2), keep-alive bit 0 clear turns the channel off. Set, it gives `drv_en` = 1, drive mode 3 and the standby set point.
- R9: In user-off state (`pwr_state` = 3), keep-alive bit 1 alone selects the same two outcomes as R8.
- R10: A channel kept alive in a low-power-off state holds its enable, mode and voltage unchanged, against register writes and through startup state (`pwr_state` = 4), until the slot strobe.
- R11: In startup state, `seq_slot` loads the normal mode behaviour and the normal set point with `drv_en` = 1 one edge later. A channel not kept alive stays off before its slot.
- R12: In off state (`pwr_state` = 0) and for unused state codes, `drv_en` is 0, drive mode 0 and `drv_volt` 0; `drv_en` is 1 exactly when the drive mode is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DW | Programmed register contents |
| stby_pin_a | input | 1 | First standby pin, asynchronous |
| stby_pin_b | input | 1 | Second standby pin, asynchronous |
| pwr_state | input | 3 | System power state code |
| seq_slot | input | 1 | Startup sequencer slot strobe for this channel |
| drv_en | output | 1 | Channel enable |
| drv_mode | output | 2 | Effective drive mode code |
| drv_volt | output | 5 | Effective voltage code |

## Verification
Register writes and power-state changes reach the drive outputs one edge after the edge that captures them. Pin changes need two more edges, for the synchronizer. Read data is combinational on the address. The bench drives on the falling edge and samples 2 ns after a rising edge. Table vectors wait four edges, so every path has settled. The directed standby test samples after the first, second and third edge, to pin down the synchronizer latency exactly. The slot test samples on the edge right after the strobe.

// File: rtl/regmode_pkg.sv
package regmode_pkg;

    localparam int VSET_W = 5;
    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        MD_OFF   = 2'd0,
        MD_PWM   = 2'd1,
        MD_PSKIP = 2'd2,
        MD_PFM   = 2'd3
    } drv_mode_e;

    typedef enum logic [2:0] {
        PS_OFF   = 3'd0,
        PS_RUN   = 3'd1,
        PS_MHOLD = 3'd2,
        PS_UOFF  = 3'd3,
        PS_START = 3'd4
    } pwr_state_e;

    localparam logic [1:0] A_MODE  = 2'd0;
    localparam logic [1:0] A_VNORM = 2'd1;
    localparam logic [1:0] A_VSTBY = 2'd2;
    localparam logic [1:0] A_KEEP  = 2'd3;

    typedef struct packed {
        logic              en;
        drv_mode_e         mode;
        logic [VSET_W-1:0] volt;
    } eff_t;

    localparam eff_t EFF_OFF = '{en: 1'b0, mode: MD_OFF, volt: '0};

    function automatic drv_mode_e decode_mode(input logic [MODE_W-1:0] code,
                                              input logic stby);
        case (code)
            4'b1110: return stby ? MD_PFM : MD_PSKIP;
            4'b1111: return MD_PFM;
            default: return MD_PWM;
        endcase
    endfunction

endpackage

// File: rtl/regmode_regs.sv
module regmode_regs
    import regmode_pkg::*;
#(
    parameter int                DW       = 8,
    parameter logic [MODE_W-1:0] MODE_RST = 4'b1110,
    parameter logic [VSET_W-1:0] VSET_RST = 5'd12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [MODE_W-1:0] mode_code,
    output logic [VSET_W-1:0] vnorm,
    output logic [VSET_W-1:0] vstby,
    output logic              mh_keep,
    output logic              uo_keep
);

    logic [MODE_W-1:0] mode_q;
    logic [VSET_W-1:0] vnorm_q;
    logic [VSET_W-1:0] vstby_q;
    logic              stby_own_q;
    logic [1:0]        keep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_RST;
            vnorm_q    <= VSET_RST;
            vstby_q    <= VSET_RST;
            stby_own_q <= 1'b0;
            keep_q     <= 2'b00;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE:  mode_q  <= wr_data[MODE_W-1:0];
                A_VNORM: vnorm_q <= wr_data[VSET_W-1:0];
                A_VSTBY: begin
                    vstby_q    <= wr_data[VSET_W-1:0];
                    stby_own_q <= 1'b1;
                end
                default: keep_q  <= wr_data[1:0];
            endcase
        end
    end

    assign mode_code = mode_q;
    assign vnorm     = vnorm_q;
    assign vstby     = stby_own_q ? vstby_q : vnorm_q;
    assign mh_keep   = keep_q[0];
    assign uo_keep   = keep_q[1];

    always_comb begin
        case (rd_addr)
            A_MODE:  rd_data = DW'(mode_q);
            A_VNORM: rd_data = DW'(vnorm_q);
            A_VSTBY: rd_data = DW'(vstby);
            default: rd_data = DW'(keep_q);
        endcase
    end

    AST_RB_MODE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_MODE) |=>
            (rd_addr != A_MODE || rd_data[MODE_W-1:0] == $past(wr_data[MODE_W-1:0]))); // R7

endmodule

// File: rtl/regmode_sync.sv
module regmode_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/regmode_core.sv
module regmode_core
    import regmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        state_i,
    input  logic              stby_i,
    input  logic              slot_i,
    input  logic [MODE_W-1:0] mode_code_i,
    input  logic [VSET_W-1:0] vnorm_i,
    input  logic [VSET_W-1:0] vstby_i,
    input  logic              mh_keep_i,
    input  logic              uo_keep_i,
    output logic              en_o,
    output logic [1:0]        mode_o,
    output logic [VSET_W-1:0] volt_o
);

    pwr_state_e ps;
    eff_t       eff_q, eff_d, eff_norm, eff_keep;
    logic       held_q, held_d;
    logic       done_q, done_d;
    logic       keep_sel;
    logic       in_lpo;

    assign ps       = pwr_state_e'(state_i);
    assign in_lpo   = (ps == PS_MHOLD) || (ps == PS_UOFF);
    assign keep_sel = (ps == PS_MHOLD) ? mh_keep_i : uo_keep_i;
    assign eff_norm = '{en: 1'b1, mode: decode_mode(mode_code_i, 1'b0), volt: vnorm_i};
    assign eff_keep = '{en: 1'b1, mode: MD_PFM, volt: vstby_i};

    always_comb begin
        eff_d  = eff_q;
        held_d = held_q;
        done_d = done_q;
        case (ps)
            PS_RUN: begin
                held_d     = 1'b0;
                done_d     = 1'b0;
                eff_d.en   = 1'b1;
                eff_d.mode = decode_mode(mode_code_i, stby_i);
                eff_d.volt = stby_i ? vstby_i : vnorm_i;
            end
            PS_MHOLD, PS_UOFF: begin
                done_d = 1'b0;
                if (!held_q) begin
                    if (keep_sel) begin
                        held_d = 1'b1;
                        eff_d  = eff_keep;
                    end else begin
                        eff_d  = EFF_OFF;
                    end
                end
            end
            PS_START: begin
                if (slot_i) begin
                    held_d = 1'b0;
                    done_d = 1'b1;
                    eff_d  = eff_norm;
                end else if (!held_q) begin
                    eff_d  = done_q ? eff_norm : EFF_OFF;
                end
            end
            default: begin
                held_d = 1'b0;
                done_d = 1'b0;
                eff_d  = EFF_OFF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eff_q  <= EFF_OFF;
            held_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            eff_q  <= eff_d;
            held_q <= held_d;
            done_q <= done_d;
        end
    end

    assign en_o   = eff_q.en;
    assign mode_o = eff_q.mode;
    assign volt_o = eff_q.volt;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ps == PS_OFF) |=> (!en_o && mode_o == MD_OFF && volt_o == '0)); // R12

    AST_EN_MATCH: assert property (@(posedge clk) disable iff (rst)
        en_o == (mode_o != MD_OFF)); // R12

    AST_KEEP_PFM: assert property (@(posedge clk) disable iff (rst)
        (in_lpo && !held_q && keep_sel) |=> (en_o && mode_o == MD_PFM)); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (held_q && (in_lpo || ps == PS_START) && !slot_i) |=>
            ($stable(volt_o) && $stable(mode_o) && en_o)); // R10

    AST_SLOT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ps == PS_START && slot_i) |=> (en_o && volt_o == $past(vnorm_i))); // R11

endmodule

// File: rtl/regmode_sel.sv
module regmode_sel
    import regmode_pkg::*;
#(
    parameter int                DW          = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [MODE_W-1:0] MODE_RST    = 4'b1110,
    parameter logic [VSET_W-1:0] VSET_RST    = 5'd12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              stby_pin_a,
    input  logic              stby_pin_b,
    input  logic [2:0]        pwr_state,
    input  logic              seq_slot,
    output logic              drv_en,
    output logic [1:0]        drv_mode,
    output logic [VSET_W-1:0] drv_volt
);

    logic [MODE_W-1:0] mode_code;
    logic [VSET_W-1:0] vnorm, vstby;
    logic              mh_keep, uo_keep;
    logic [1:0]        pins_s;
    logic              stby_q;

    regmode_regs #(.DW(DW), .MODE_RST(MODE_RST), .VSET_RST(VSET_RST)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mode_code(mode_code),
        .vnorm(vnorm), .vstby(vstby), .mh_keep(mh_keep), .uo_keep(uo_keep)
    );

    regmode_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst(rst), .d({stby_pin_b, stby_pin_a}), .q(pins_s)
    );

    // R1: standby is qualified only when both synchronized pins are high
    assign stby_q = pins_s[0] & pins_s[1];

    regmode_core u_core (
        .clk(clk), .rst(rst), .state_i(pwr_state), .stby_i(stby_q), .slot_i(seq_slot),
        .mode_code_i(mode_code), .vnorm_i(vnorm), .vstby_i(vstby),
        .mh_keep_i(mh_keep), .uo_keep_i(uo_keep),
        .en_o(drv_en), .mode_o(drv_mode), .volt_o(drv_volt)
    );

endmodule

// File: tb/regmode_sel_test.sv
`timescale 1ns/1ps
module regmode_sel_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pin_a = 1'b0, pin_b = 1'b0;
    logic [2:0] pstate = 3'd0;
    logic       slot = 1'b0;
    logic       drv_en;
    logic [1:0] drv_mode;
    logic [4:0] drv_volt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    regmode_sel uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .stby_pin_a(pin_a), .stby_pin_b(pin_b),
        .pwr_state(pstate), .seq_slot(slot), .drv_en(drv_en), .drv_mode(drv_mode),
        .drv_volt(drv_volt)
    );

    // mode, pin_a, pin_b, vnorm, vstby, expected mode, expected volt
    localparam logic [22:0] VEC [9] = '{
        {4'b1110, 1'b0, 1'b0, 5'd10, 5'd3,  2'd2, 5'd10},
        {4'b1110, 1'b1, 1'b1, 5'd10, 5'd3,  2'd3, 5'd3 },
        {4'b1110, 1'b1, 1'b0, 5'd10, 5'd3,  2'd2, 5'd10},
        {4'b1110, 1'b0, 1'b1, 5'd12, 5'd4,  2'd2, 5'd12},
        {4'b1111, 1'b0, 1'b0, 5'd7,  5'd20, 2'd3, 5'd7 },
        {4'b1111, 1'b1, 1'b1, 5'd7,  5'd20, 2'd3, 5'd20},
        {4'b0101, 1'b1, 1'b1, 5'd31, 5'd0,  2'd1, 5'd0 },
        {4'b0000, 1'b0, 1'b0, 5'd31, 5'd0,  2'd1, 5'd31},
        {4'b1101, 1'b1, 1'b1, 5'd1,  5'd2,  2'd1, 5'd2 }
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pstate = 3'd0; pin_a = 0; pin_b = 0; slot = 0;
        edges(2);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_out(input string req, input int en, input int md, input int v);
        chk({req, " enable"}, drv_en, en);
        chk({req, " mode"}, drv_mode, md);
        chk({req, " volt"}, drv_volt, v);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state: R6 register defaults, R12 off outputs
        edges(3);
        @(negedge clk); rst = 1'b0;
        edges(1);
        check_out("R12 reset", 0, 0, 0);
        rd_addr = 2'd0; #1; chk("R6 reset mode field", rd_data, 8'hE);
        rd_addr = 2'd1; #1; chk("R6 reset normal setpoint", rd_data, 12);
        rd_addr = 2'd2; #1; chk("R6 reset standby setpoint", rd_data, 12);
        rd_addr = 2'd3; #1; chk("R6 reset keep bits", rd_data, 0);

        // R6 standby set point tracks normal until written
        wr(2'd1, 8'd9);
        rd_addr = 2'd2; #1; chk("R6 standby tracks normal", rd_data, 9);
        @(negedge clk); pstate = 3'd1; pin_a = 1; pin_b = 1;
        edges(4);
        check_out("R6 tracked standby in run", 1, 3, 9);

        // Table walk in run state: R1 R2 R3 R4 R5
        foreach (VEC[i]) begin
            logic [22:0] v;
            v = VEC[i];
            wr(2'd0, {4'b0, v[22:19]});
            wr(2'd1, {3'b0, v[16:12]});
            wr(2'd2, {3'b0, v[11:7]});
            @(negedge clk); pin_a = v[18]; pin_b = v[17];
            edges(4);
            check_out($sformatf("R1 R2 R3 R4 R5 vector %0d", i), 1, v[6:5], v[4:0]);
        end

        // R1 exact synchronizer latency; R7 readback of programmed field
        wr(2'd0, 8'hE); wr(2'd1, 8'd5); wr(2'd2, 8'd17);
        @(negedge clk); pin_a = 0; pin_b = 0;
        edges(4);
        @(negedge clk); pin_a = 1; pin_b = 1;
        edges(1); chk("R1 latency edge1 mode", drv_mode, 2);
        edges(1); chk("R1 latency edge2 mode", drv_mode, 2);
        edges(1); chk("R1 latency edge3 mode", drv_mode, 3);
        chk("R5 standby volt", drv_volt, 17);
        rd_addr = 2'd0; #1; chk("R7 readback while PFM", rd_data, 8'hE);

        // R8 memory hold
        wr(2'd3, 8'h0);
        @(negedge clk); pstate = 3'd2;
        edges(2);
        check_out("R8 hold keep clear", 0, 0, 0);
        do_reset();
        wr(2'd0, 8'hE); wr(2'd1, 8'd6); wr(2'd2, 8'd21); wr(2'd3, 8'h1);
        @(negedge clk); pstate = 3'd2;
        edges(2);
        check_out("R8 hold keep set", 1, 3, 21);

        // R9 user off uses its own bit
        do_reset();
        wr(2'd3, 8'h1);
        @(negedge clk); pstate = 3'd3;
        edges(2);
        check_out("R9 user off with only hold bit", 0, 0, 0);
        do_reset();
        wr(2'd0, 8'hE); wr(2'd1, 8'd8); wr(2'd2, 8'd19); wr(2'd3, 8'h2);
        @(negedge clk); pstate = 3'd3;
        edges(2);
        check_out("R9 user off keep set", 1, 3, 19);

        // R10 settings frozen against writes and into startup
        wr(2'd2, 8'd2); wr(2'd0, 8'h0);
        edges(1);
        check_out("R10 frozen after writes", 1, 3, 19);
        wr(2'd0, 8'hE);
        @(negedge clk); pstate = 3'd4;
        edges(3);
        check_out("R10 frozen in startup", 1, 3, 19);

        // R11 slot loads normal settings
        @(negedge clk); slot = 1;
        @(negedge clk); slot = 0;
        #1;
        check_out("R11 slot reload", 1, 2, 8);

        // R11 channel not kept alive stays off until its slot
        @(negedge clk); pstate = 3'd0;
        edges(2);
        check_out("R12 off after startup", 0, 0, 0);
        @(negedge clk); pstate = 3'd4;
        edges(3);
        check_out("R11 off before slot", 0, 0, 0);
        wr(2'd1, 8'd27);
        @(negedge clk); slot = 1;
        @(negedge clk); slot = 0;
        #1;
        check_out("R11 on after slot", 1, 2, 27);

        // R12 unused state code
        @(negedge clk); pstate = 3'd6;
        edges(2);
        check_out("R12 unused state", 0, 0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule